// File: doc/BRIEF.md
# Wait-State Wakeup and Vector Selector

This block sits next to a small 8-bit processor core. While the core idles in its low-power wait state, the block watches every wake source. It raises a wake signal that restarts the core clock, and it names the address pair the program counter is loaded from. The sources are:

- a dedicated active-low interrupt pin;
- four port pins that can be enabled as interrupt inputs;
- request lines from a core timer, a programmable timer, a serial shifter and an analog comparator;
- a watchdog timeout;
- an active-low reset pin.

The external pins are edge-sensitive. The dedicated pin reacts to a falling edge and the port pins to a rising edge. Each pin passes through a synchronizer and a previous-value compare. A detected edge stays latched until the core acknowledges it. The peripheral requests are levels and act at once. Reset sources override every interrupt and ignore the global interrupt mask. The wake output is decoded directly from the request state, so leaving wait adds no cycles.

The vector output gives the address of the high byte of the pair; the low byte sits at that address plus one. The interrupt pin and the port pins share one pair.

Top module: `wake_vec_sel`

## Requirements
- R1: After the block reset (rst_ni low, then high) with all sources idle, wake_o is 0, rst_sel_o is 0 and vec_o is 0x1FFE.
- R2: A high-to-low transition on irq_ni latches an external request. vec_o shows 0x1FFA from the third rising clock edge after the change, and not at the second.
- R3: With port_irq_en_i at 1, a low-to-high transition on any port_irq_i bit latches the external request and gives vec_o 0x1FFA. With port_irq_en_i at 0, such a transition leaves vec_o at 0x1FFE.
- R4: A high level on ctmr_req_i (core timer overflow or periodic tick) selects 0x1FF8.
- R5: A high level on ptmr_req_i (capture, compare or overflow) selects 0x1FF6.
- R6: A high level on ser_req_i (8-bit transfer done) selects 0x1FF4.
- R7: A high level on cmp_req_i (comparator trip) selects 0x1FF2.
- R8: wdog_to_i high or hard_rst_ni low sets rst_sel_o to 1 and vec_o to 0x1FFE. While in_wait_i is 1 this also sets wake_o to 1, whatever int_mask_i is.
- R9: When several interrupts are active, the order of precedence is external, core timer, programmable timer, serial, analog. Reset sources rank above all of them.
- R10: While int_mask_i is 1, interrupt sources do not raise wake_o.
- R11: wake_o is in_wait_i AND (reset source OR (an interrupt is active AND int_mask_i is 0)). It follows its inputs in the same cycle, with no register in the path.
- R12: A latched external request holds across any number of cycles until ack_i is sampled high on a clock edge, which clears it.
- R13: A rising edge on irq_ni and a falling edge on a port pin create no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| in_wait_i | input | 1 | Core is in the wait state |
| int_mask_i | input | 1 | Global interrupt mask, 1 = masked |
| ack_i | input | 1 | Clears the latched external request |
| irq_ni | input | 1 | Dedicated interrupt pin, falling-edge active |
| port_irq_en_i | input | 1 | Enables the port pins as interrupts |
| port_irq_i | input | 4 | Port interrupt pins, rising-edge active |
| ctmr_req_i | input | 1 | Core timer request |
| ptmr_req_i | input | 1 | Programmable timer request |
| ser_req_i | input | 1 | Serial transfer-done request |
| cmp_req_i | input | 1 | Analog comparator request |
| wdog_to_i | input | 1 | Watchdog timeout |
| hard_rst_ni | input | 1 | Reset pin, active low |
| wake_o | output | 1 | Restart core clock |
| vec_o | output | 13 | Vector high-byte address |
| rst_sel_o | output | 1 | Selected source is a reset |

## Verification
The bench builds the block with its defaults: four port pins, two synchronizer stages and a top vector of 0x1FFE. These values place every vector of the table in the documented 0x1FF2 to 0x1FFE range. The two-stage chain also puts the first-visible edge at a fixed third clock edge, which the bench checks against the second edge. The level sources are walked from a table that covers each source alone, mixed priority sets, the mask and the reset overrides. Directed cases cover edge latency, latch hold and clear, port enable gating and the wrong-polarity edges.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int ADDR_W = 13;
  localparam int N_INT  = 5;  // ext, core timer, prog timer, serial, analog
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int   N      = 4,
  parameter int   STAGES = 2,
  parameter bit   RISE   = 1'b1,
  parameter bit   IDLE   = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= {STAGES{IDLE}};
        prev_q <= IDLE;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], pin_i[g]};
        prev_q <= sync_q[STAGES-1];
      end
    end
    if (RISE) begin : g_rise
      assign edge_o[g] = sync_q[STAGES-1] & ~prev_q;
    end else begin : g_fall
      assign edge_o[g] = ~sync_q[STAGES-1] & prev_q;
    end
  end
endmodule

// File: rtl/wake_pend.sv
module wake_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  // set wins over clear so a fresh edge is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end
endmodule

// File: rtl/wake_prio.sv
module wake_prio
  import wake_pkg::*;
#(
  parameter int                 NI      = N_INT,
  parameter logic [ADDR_W-1:0]  VEC_TOP = 13'h1FFE
) (
  input  logic              rst_req_i,
  input  logic [NI-1:0]     int_req_i,   // bit 0 highest priority
  output logic [ADDR_W-1:0] vec_o,
  output logic              sel_rst_o,
  output logic              any_int_o
);
  localparam int IW = $clog2(NI + 1);
  logic [IW-1:0] idx;

  always_comb begin
    idx = IW'(NI);
    for (int i = NI - 1; i >= 0; i--)
      if (int_req_i[i]) idx = IW'(i);
  end

  assign any_int_o = |int_req_i;
  assign sel_rst_o = rst_req_i;

  // slot just below the reset pair is skipped; interrupts then step down by 2
  always_comb begin
    if (rst_req_i || !any_int_o) vec_o = VEC_TOP;
    else vec_o = VEC_TOP - ADDR_W'(4) - ADDR_W'({idx, 1'b0});
  end
endmodule

// File: rtl/wake_vec_sel.sv
module wake_vec_sel
  import wake_pkg::*;
#(
  parameter int                N_PORT  = 4,
  parameter int                SYNC_ST = 2,
  parameter logic [ADDR_W-1:0] VEC_TOP = 13'h1FFE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_wait_i,
  input  logic              int_mask_i,
  input  logic              ack_i,
  input  logic              irq_ni,
  input  logic              port_irq_en_i,
  input  logic [N_PORT-1:0] port_irq_i,
  input  logic              ctmr_req_i,
  input  logic              ptmr_req_i,
  input  logic              ser_req_i,
  input  logic              cmp_req_i,
  input  logic              wdog_to_i,
  input  logic              hard_rst_ni,
  output logic              wake_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              rst_sel_o
);
  logic              irq_edge;
  logic [N_PORT-1:0] port_edge;
  logic              ext_set, ext_pend;
  logic              rst_req, any_int;
  logic [N_INT-1:0]  int_req;

  wake_edge_det #(.N(1), .STAGES(SYNC_ST), .RISE(1'b0), .IDLE(1'b1)) i_irq_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(irq_ni), .edge_o(irq_edge)
  );

  wake_edge_det #(.N(N_PORT), .STAGES(SYNC_ST), .RISE(1'b1), .IDLE(1'b0)) i_port_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(port_irq_i), .edge_o(port_edge)
  );

  assign ext_set = irq_edge | (port_irq_en_i & (|port_edge));

  wake_pend i_ext_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ext_set), .clr_i(ack_i), .pend_o(ext_pend)
  );

  assign int_req = {cmp_req_i, ser_req_i, ptmr_req_i, ctmr_req_i, ext_pend};
  assign rst_req = wdog_to_i | ~hard_rst_ni;

  wake_prio #(.NI(N_INT), .VEC_TOP(VEC_TOP)) i_prio (
    .rst_req_i(rst_req), .int_req_i(int_req), .vec_o(vec_o),
    .sel_rst_o(rst_sel_o), .any_int_o(any_int)
  );

  // combinational: no recovery cycle on leaving wait
  assign wake_o = in_wait_i & (rst_req | (any_int & ~int_mask_i));
endmodule

// File: rtl/wake_vec_sel_chk.sv
module wake_vec_sel_chk
  import wake_pkg::*;
#(
  parameter logic [ADDR_W-1:0] VEC_TOP = 13'h1FFE
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_wait_i,
  input logic              int_mask_i,
  input logic              ack_i,
  input logic              ctmr_req_i,
  input logic              wdog_to_i,
  input logic              hard_rst_ni,
  input logic              wake_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic              rst_sel_o
);
  localparam logic [ADDR_W-1:0] V_EXT = VEC_TOP - ADDR_W'(4);
  localparam logic [ADDR_W-1:0] V_CT  = VEC_TOP - ADDR_W'(6);

  assert_reset_over_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_to_i || !hard_rst_ni) |-> (rst_sel_o && vec_o == VEC_TOP && (wake_o || !in_wait_i)));

  assert_mask_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_mask_i && !rst_sel_o) |-> !wake_o);

  assert_no_wake_outside_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_wait_i |-> !wake_o);

  assert_same_cycle_wake_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_wait_i && ctmr_req_i && !int_mask_i) |-> wake_o);

  assert_ct_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctmr_req_i && !rst_sel_o) |-> (vec_o == V_EXT || vec_o == V_CT));

  assert_ext_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o == V_EXT && !rst_sel_o && !ack_i) |=> (vec_o == V_EXT || rst_sel_o));
endmodule

bind wake_vec_sel wake_vec_sel_chk #(.VEC_TOP(VEC_TOP)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_wait_i(in_wait_i), .int_mask_i(int_mask_i),
  .ack_i(ack_i), .ctmr_req_i(ctmr_req_i), .wdog_to_i(wdog_to_i),
  .hard_rst_ni(hard_rst_ni), .wake_o(wake_o), .vec_o(vec_o), .rst_sel_o(rst_sel_o)
);

// File: tb/test_wake_vec_sel.sv
module test_wake_vec_sel;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_wait, mask, ack, irq_n, port_en, ct, pt, ser, cmp, wdog, hrst_n;
  logic [3:0]  port;
  logic        wake, rsel;
  logic [12:0] vec;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  wake_vec_sel i_wake_vec_sel (
    .clk_i(clk), .rst_ni(rst_ni), .in_wait_i(in_wait), .int_mask_i(mask), .ack_i(ack),
    .irq_ni(irq_n), .port_irq_en_i(port_en), .port_irq_i(port), .ctmr_req_i(ct),
    .ptmr_req_i(pt), .ser_req_i(ser), .cmp_req_i(cmp), .wdog_to_i(wdog),
    .hard_rst_ni(hrst_n), .wake_o(wake), .vec_o(vec), .rst_sel_o(rsel)
  );

  // [27:24] req, [23:16] {hrst_n,wdog,ct,pt,ser,cmp,mask,wait}, [15] wake, [14] rsel, [12:0] vec
  localparam int NV = 13;
  localparam logic [27:0] TBL [NV] = '{
    {4'd1,  8'b1000_0001, 2'b00, 1'b0, 13'h1FFE},  // R1 idle
    {4'd4,  8'b1010_0001, 2'b10, 1'b0, 13'h1FF8},  // R4
    {4'd5,  8'b1001_0001, 2'b10, 1'b0, 13'h1FF6},  // R5
    {4'd6,  8'b1000_1001, 2'b10, 1'b0, 13'h1FF4},  // R6
    {4'd7,  8'b1000_0101, 2'b10, 1'b0, 13'h1FF2},  // R7
    {4'd9,  8'b1011_1101, 2'b10, 1'b0, 13'h1FF8},  // R9
    {4'd9,  8'b1001_1101, 2'b10, 1'b0, 13'h1FF6},  // R9
    {4'd9,  8'b1000_1101, 2'b10, 1'b0, 13'h1FF4},  // R9
    {4'd10, 8'b1010_0011, 2'b00, 1'b0, 13'h1FF8},  // R10
    {4'd8,  8'b1110_0011, 2'b11, 1'b0, 13'h1FFE},  // R8 watchdog
    {4'd8,  8'b0000_0111, 2'b11, 1'b0, 13'h1FFE},  // R8 pin
    {4'd11, 8'b1010_0000, 2'b00, 1'b0, 13'h1FF8},  // R11 not waiting
    {4'd8,  8'b0000_0000, 2'b01, 1'b0, 13'h1FFE}   // R8 not waiting
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic levels(input logic [7:0] v);
    {hrst_n, wdog, ct, pt, ser, cmp, mask, in_wait} = v;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    levels(8'b1000_0001);
    ack = 0; irq_n = 1; port_en = 0; port = 4'h0;
    tick(2);
    rst_ni = 1'b1;
    tick(2);
    #1;
    chk("R1 vec", 16'(vec), 16'h1FFE);
    chk("R1 wake/rsel", 16'({wake, rsel}), 16'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      levels(TBL[i][23:16]);
      #1;
      chk($sformatf("R%0d row%0d vec", TBL[i][27:24], i), 16'(vec), 16'(TBL[i][12:0]));
      chk($sformatf("R%0d row%0d wake/rsel", TBL[i][27:24], i), 16'({wake, rsel}),
          16'(TBL[i][15:14]));
    end

    // R2: falling edge, 3-edge latency
    @(negedge clk); levels(8'b1000_0001);
    irq_n = 0;
    tick(2); #1;
    chk("R2 not yet", 16'(vec), 16'h1FFE);
    tick(1); #1;
    chk("R2 vec", 16'(vec), 16'h1FFA);
    chk("R2 wake", 16'(wake), 16'h1);
    // R12: hold across cycles and pin release
    irq_n = 1;
    tick(6); #1;
    chk("R12 hold", 16'(vec), 16'h1FFA);
    // R9: ext over core timer
    ct = 1; #1;
    chk("R9 ext over ct", 16'(vec), 16'h1FFA);
    ct = 0;
    // R10: masked latched request
    mask = 1; #1;
    chk("R10 masked", 16'(wake), 16'h0);
    mask = 0;
    // R8 over ext
    wdog = 1; #1;
    chk("R8 over ext", 16'({rsel, vec}), 16'h3FFE);
    wdog = 0;
    // R12: ack clears
    @(negedge clk); ack = 1;
    tick(1); ack = 0; #1;
    chk("R12 cleared", 16'(vec), 16'h1FFE);
    // R13: rising on irq already passed; no new request
    tick(4); #1;
    chk("R13 irq rise", 16'(vec), 16'h1FFE);

    // R3: disabled port ignored
    port = 4'b0100;
    tick(5); #1;
    chk("R3 disabled", 16'(vec), 16'h1FFE);
    port = 4'b0000;
    tick(4);
    port_en = 1;
    port = 4'b0010;
    tick(3); #1;
    chk("R3 enabled", 16'(vec), 16'h1FFA);
    @(negedge clk); ack = 1;
    tick(1); ack = 0;
    // R13: falling port edge ignored
    port = 4'b0000;
    tick(5); #1;
    chk("R13 port fall", 16'(vec), 16'h1FFE);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule